// File: doc/BRIEF.md
# Multiprocessor Programmable Interrupt Controller

This block collects a parameterised set of external interrupt inputs and delivers them to a small number of processors, with one request line per processor. Each input has a configuration word and a routing mask. The configuration word sets the mask, edge or level detection, active polarity, a 4-bit priority and an 8-bit vector. The routing mask has one bit per processor. Each processor has a task priority, and a processor is interrupted only by a routed, unmasked, pending source whose priority is above both its task priority and the priority of anything it already has in service.

Software reaches all state through a simple synchronous 32-bit register bus. A read of a processor's acknowledge word returns the winning vector and moves that source into service. When no source is eligible, the read returns a programmable spurious vector. A write to the processor's end-of-interrupt word retires the highest-priority interrupt in service on that processor. A global configuration word provides a self-clearing soft reset of all source state and a plain legacy pass-through disable bit. A read-only feature word reports the build parameters.

Register map (byte addresses): feature 0x000, global configuration 0x004, spurious vector 0x008. Source n uses configuration word 0x100+8n and routing mask 0x104+8n. Processor c uses task priority 0x200+16c, acknowledge 0x204+16c and end-of-interrupt 0x208+16c.

Top module: `mpic_core`

## Requirements
- R1: The source configuration word holds vector in bits 7:0, priority in bits 11:8, polarity in bit 16 (1 = active high / rising), sense in bit 17 (1 = level, 0 = edge) and mask in bit 31. All of these fields read back exactly as written. Bit 30 is read-only.
- R2: A source whose mask bit is 1 never drives any processor request line. A write to the mask bit is visible on the very next read.
- R3: Bit 30 (activity) of a source's configuration word reads 1 while that source is pending or in service on any processor, and 0 otherwise.
- R4: A source can interrupt processor c only if bit c of its routing mask is 1.
- R5: A source is eligible for a processor only when its priority is strictly greater than that processor's task priority (bits 3:0 of the task word) and strictly greater than the highest priority the processor has in service. A task priority of 0xF therefore blocks everything, and a higher-priority source can preempt a lower one that is in service.
- R6: A read of a processor's acknowledge word returns the vector of the highest-priority eligible source and puts that source in service. Equal priorities are resolved in favour of the lowest source number. With no eligible source, the read returns the spurious vector (word 0x008, bits 7:0), and that read changes nothing.
- R7: Any write to a processor's end-of-interrupt word retires that processor's highest-priority in-service source. A read of that word returns 0 and has no effect.
- R8: Writing 1 to bit 0 of the global configuration word resets all source state on the following cycle. Every source becomes masked, edge-sensed, active-high, with priority 0, vector 0 and routing mask 0, and nothing remains pending or in service. Bit 0 reads 1 for one cycle and then 0 by itself. Bit 1 is a plain read/write bit, and task priorities are kept.
- R9: The feature word reads version code in bits 3:0, number of sources minus one in bits 15:8 and number of processors minus one in bits 23:16.
- R10: An edge source latches pending on the active edge (rising when polarity is 1, falling when 0), and the acknowledge clears it. A level source is pending exactly while its input is at the active level.
- R11: After the reset pin, every source is masked with priority 0, every task priority is 0xF, the spurious vector is 0xFF and all request lines are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_src | input | NUM_SRC | External interrupt inputs |
| bus_sel | input | 1 | Bus access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the access |
| cpu_irq | output | NUM_CPU | Interrupt request per processor |

## Verification
The hardest state to reach is a processor holding two nested in-service sources while a third source of equal priority waits. Reaching it takes acknowledges interleaved with input changes. The stimulus raises a low-priority source and acknowledges it, then raises a higher one and acknowledges that too, then raises an equal-priority peer. An acknowledge must then return the spurious vector. The inputs are then dropped, and successive end-of-interrupt writes must unwind the sources in priority order, which the activity bit of the older source makes visible.

// File: rtl/mpic_pkg.sv
package mpic_pkg;
  localparam int VEC_W = 8;
  localparam int PRI_W = 4;

  localparam logic [11:0] A_FEAT = 12'h000;
  localparam logic [11:0] A_GCFG = 12'h004;
  localparam logic [11:0] A_SPUR = 12'h008;
  localparam logic [3:0]  PAGE_SRC = 4'h1;
  localparam logic [3:0]  PAGE_CPU = 4'h2;

  localparam int B_MASK  = 31;
  localparam int B_ACT   = 30;
  localparam int B_SENSE = 17;
  localparam int B_POL   = 16;

  typedef struct packed {
    logic             mask;
    logic             sense;
    logic             pol;
    logic [PRI_W-1:0] pri;
    logic [VEC_W-1:0] vec;
  } srccfg_t;

  localparam srccfg_t CFG_RST = '{mask: 1'b1, sense: 1'b0, pol: 1'b1,
                                  pri: '0, vec: '0};
endpackage

// File: rtl/mpic_src.sv
module mpic_src
  import mpic_pkg::*;
#(
  parameter int NUM_CPU = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               irq_in,
  input  logic               wr_cfg,
  input  logic               wr_dst,
  input  logic [31:0]        wdata,
  input  logic               take,
  input  logic               busy,
  output srccfg_t            cfg,
  output logic [NUM_CPU-1:0] dest,
  output logic               cand,
  output logic               active
);
  srccfg_t            cfg_q, cfg_d;
  logic [NUM_CPU-1:0] dst_q, dst_d;
  logic               in_q, prev_q, edge_q, edge_d;
  logic               lvl_act, prev_act, edge_hit, pend;

  always_comb begin
    lvl_act  = (in_q == cfg_q.pol);
    prev_act = (prev_q == cfg_q.pol);
    edge_hit = lvl_act && !prev_act;
    pend     = cfg_q.sense ? lvl_act : edge_q;

    edge_d = edge_q;
    if (take)     edge_d = 1'b0;
    if (edge_hit) edge_d = 1'b1;
    if (clr)      edge_d = 1'b0;

    cfg_d = cfg_q;
    if (wr_cfg) begin
      cfg_d.mask  = wdata[B_MASK];
      cfg_d.sense = wdata[B_SENSE];
      cfg_d.pol   = wdata[B_POL];
      cfg_d.pri   = wdata[8 +: PRI_W];
      cfg_d.vec   = wdata[0 +: VEC_W];
    end
    if (clr) cfg_d = CFG_RST;

    dst_d = dst_q;
    if (wr_dst) dst_d = wdata[NUM_CPU-1:0];
    if (clr)    dst_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= CFG_RST;
      dst_q  <= '0;
      in_q   <= 1'b0;
      prev_q <= 1'b0;
      edge_q <= 1'b0;
    end else begin
      cfg_q  <= cfg_d;
      dst_q  <= dst_d;
      in_q   <= irq_in;
      prev_q <= in_q;
      edge_q <= edge_d;
    end
  end

  assign cfg    = cfg_q;
  assign dest   = dst_q;
  assign cand   = pend && !cfg_q.mask && !busy;
  assign active = pend || busy;

  // R8: soft reset leaves the source masked at priority 0
  assert_clr_masks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cfg_q.mask && cfg_q.pri == '0 && dst_q == '0 && !edge_q));

  // R10: a level source with its input idle is never pending
  assert_level_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q.sense && (in_q != cfg_q.pol) && !busy) |-> !active);
endmodule

// File: rtl/mpic_arb.sv
module mpic_arb
  import mpic_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int IW      = 3
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            clr,
  input  logic [NUM_SRC-1:0]              cand,
  input  logic [NUM_SRC-1:0][PRI_W-1:0]   pri,
  input  logic [NUM_SRC-1:0]              route,
  input  logic                            tpri_we,
  input  logic [PRI_W-1:0]                tpri_wdata,
  input  logic                            ack,
  input  logic                            eoi,
  output logic                            irq,
  output logic [IW-1:0]                   win,
  output logic [PRI_W-1:0]                tpri,
  output logic [NUM_SRC-1:0]              ins
);
  logic [PRI_W-1:0]   tpri_q, tpri_d;
  logic [NUM_SRC-1:0] ins_q, ins_d;
  logic [PRI_W-1:0]   best_pri, ins_pri;
  logic [IW-1:0]      best_idx, ret_idx;
  logic               found, has_ins, eligible;

  // winner search: strictly greater replaces, so ties keep the lower index
  always_comb begin
    best_pri = '0;
    best_idx = '0;
    found    = 1'b0;
    ins_pri  = '0;
    ret_idx  = '0;
    has_ins  = 1'b0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (cand[i] && route[i] && (!found || pri[i] > best_pri)) begin
        found    = 1'b1;
        best_pri = pri[i];
        best_idx = IW'(i);
      end
      if (ins_q[i] && (!has_ins || pri[i] > ins_pri)) begin
        has_ins = 1'b1;
        ins_pri = pri[i];
        ret_idx = IW'(i);
      end
    end
    eligible = found && (best_pri > tpri_q) && (!has_ins || best_pri > ins_pri);
  end

  always_comb begin
    ins_d = ins_q;
    if (eoi && has_ins)  ins_d[ret_idx]  = 1'b0;
    if (ack && eligible) ins_d[best_idx] = 1'b1;
    if (clr)             ins_d = '0;
    tpri_d = tpri_we ? tpri_wdata : tpri_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ins_q  <= '0;
      tpri_q <= '1;
    end else begin
      ins_q  <= ins_d;
      tpri_q <= tpri_d;
    end
  end

  assign irq  = eligible;
  assign win  = best_idx;
  assign tpri = tpri_q;
  assign ins  = ins_q;

  // R6: an acknowledged winner is in service on the next cycle
  assert_ack_marks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && irq && !clr) |=> ins_q[$past(win)]);

  // R7: without acknowledge, end-of-interrupt or soft reset the in-service set holds
  assert_ins_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack && !eoi && !clr) |=> $stable(ins_q));
endmodule

// File: rtl/mpic_core.sv
module mpic_core
  import mpic_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int NUM_CPU = 2,
  parameter int VERSION = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_src,
  input  logic               bus_sel,
  input  logic               bus_we,
  input  logic [11:0]        bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic [NUM_CPU-1:0] cpu_irq
);
  localparam int IW = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
  localparam int CW = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1;

  // bus decode
  logic [3:0]    page;
  logic [IW-1:0] s_sel;
  logic [CW-1:0] c_sel;
  logic          s_reg, src_ok, cpu_ok, src_hit, cpu_hit;
  logic [1:0]    c_reg;

  assign page    = bus_addr[11:8];
  assign s_sel   = bus_addr[3 +: IW];
  assign s_reg   = bus_addr[2];
  assign c_sel   = bus_addr[4 +: CW];
  assign c_reg   = bus_addr[3:2];
  assign src_ok  = (int'(bus_addr[7:3]) < NUM_SRC) && (bus_addr[1:0] == 2'b00);
  assign cpu_ok  = (int'(bus_addr[7:4]) < NUM_CPU) && (bus_addr[1:0] == 2'b00);
  assign src_hit = bus_sel && (page == PAGE_SRC) && src_ok;
  assign cpu_hit = bus_sel && (page == PAGE_CPU) && cpu_ok;

  // global registers
  logic [VEC_W-1:0] spur_q, spur_d;
  logic             ptd_q, ptd_d, rstb_q, rstb_d, clr;
  logic             gcfg_wr, spur_wr;

  assign gcfg_wr = bus_sel && bus_we && (bus_addr == A_GCFG);
  assign spur_wr = bus_sel && bus_we && (bus_addr == A_SPUR);

  always_comb begin
    spur_d = spur_wr ? bus_wdata[VEC_W-1:0] : spur_q;
    ptd_d  = gcfg_wr ? bus_wdata[1] : ptd_q;
    rstb_d = gcfg_wr && bus_wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      spur_q <= '1;
      ptd_q  <= 1'b0;
      rstb_q <= 1'b0;
    end else begin
      spur_q <= spur_d;
      ptd_q  <= ptd_d;
      rstb_q <= rstb_d;
    end
  end

  assign clr = rstb_q;

  // per-source and per-processor structures
  srccfg_t                     cfg_a [NUM_SRC];
  logic [NUM_CPU-1:0]          dest_a [NUM_SRC];
  logic [NUM_SRC-1:0][PRI_W-1:0] pri_a;
  logic [NUM_SRC-1:0]          cand_v, act_v, busy_v, take_v;
  logic [NUM_SRC-1:0]          route_a [NUM_CPU];
  logic [NUM_SRC-1:0]          ins_a [NUM_CPU];
  logic [IW-1:0]               win_a [NUM_CPU];
  logic [PRI_W-1:0]            tpri_a [NUM_CPU];
  logic [NUM_CPU-1:0]          ack_v, eoi_v, tpw_v;

  always_comb begin
    busy_v = '0;
    take_v = '0;
    for (int c = 0; c < NUM_CPU; c++) begin
      busy_v = busy_v | ins_a[c];
      if (ack_v[c] && cpu_irq[c]) take_v[win_a[c]] = 1'b1;
    end
  end

  for (genvar n = 0; n < NUM_SRC; n++) begin : g_src
    logic wr_c, wr_d;
    assign wr_c = src_hit && bus_we && (s_sel == IW'(n)) && !s_reg;
    assign wr_d = src_hit && bus_we && (s_sel == IW'(n)) && s_reg;
    mpic_src #(.NUM_CPU(NUM_CPU)) u_src (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (clr),
      .irq_in (irq_src[n]),
      .wr_cfg (wr_c),
      .wr_dst (wr_d),
      .wdata  (bus_wdata),
      .take   (take_v[n]),
      .busy   (busy_v[n]),
      .cfg    (cfg_a[n]),
      .dest   (dest_a[n]),
      .cand   (cand_v[n]),
      .active (act_v[n])
    );
    assign pri_a[n] = cfg_a[n].pri;
    for (genvar c = 0; c < NUM_CPU; c++) begin : g_route
      assign route_a[c][n] = dest_a[n][c];
    end
  end

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    assign tpw_v[c] = cpu_hit && bus_we  && (c_sel == CW'(c)) && (c_reg == 2'd0);
    assign ack_v[c] = cpu_hit && !bus_we && (c_sel == CW'(c)) && (c_reg == 2'd1);
    assign eoi_v[c] = cpu_hit && bus_we  && (c_sel == CW'(c)) && (c_reg == 2'd2);
    mpic_arb #(.NUM_SRC(NUM_SRC), .IW(IW)) u_arb (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr        (clr),
      .cand       (cand_v),
      .pri        (pri_a),
      .route      (route_a[c]),
      .tpri_we    (tpw_v[c]),
      .tpri_wdata (bus_wdata[PRI_W-1:0]),
      .ack        (ack_v[c]),
      .eoi        (eoi_v[c]),
      .irq        (cpu_irq[c]),
      .win        (win_a[c]),
      .tpri       (tpri_a[c]),
      .ins        (ins_a[c])
    );

    // R2: a masked source is never presented
    assert_mask_blocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_irq[c] |-> !cfg_a[win_a[c]].mask);
    // R4: only routed sources reach this processor
    assert_route_R4: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_irq[c] |-> dest_a[win_a[c]][c]);
    // R5: presented priority exceeds the task priority
    assert_task_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_irq[c] |-> (cfg_a[win_a[c]].pri > tpri_a[c]));
  end

  // read mux
  srccfg_t s_cfg;
  assign s_cfg = cfg_a[s_sel];

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == A_FEAT) begin
      bus_rdata = {8'h00, 8'(NUM_CPU - 1), 8'(NUM_SRC - 1), 4'h0, 4'(VERSION)};
    end else if (bus_addr == A_GCFG) begin
      bus_rdata = {30'd0, ptd_q, rstb_q};
    end else if (bus_addr == A_SPUR) begin
      bus_rdata = {{(32-VEC_W){1'b0}}, spur_q};
    end else if ((page == PAGE_SRC) && src_ok) begin
      if (s_reg) bus_rdata = {{(32-NUM_CPU){1'b0}}, dest_a[s_sel]};
      else       bus_rdata = {s_cfg.mask, act_v[s_sel], 12'd0, s_cfg.sense, s_cfg.pol,
                              4'd0, s_cfg.pri, s_cfg.vec};
    end else if ((page == PAGE_CPU) && cpu_ok) begin
      case (c_reg)
        2'd0:    bus_rdata = {28'd0, tpri_a[c_sel]};
        2'd1:    bus_rdata = {24'd0, cpu_irq[c_sel] ? cfg_a[win_a[c_sel]].vec : spur_q};
        default: bus_rdata = '0;
      endcase
    end
  end

  // R8: the soft reset bit never stays set without a fresh write
  assert_selfclear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rstb_q && !gcfg_wr) |=> !rstb_q);
endmodule

// File: tb/sim_mpic_core.sv
module sim_mpic_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  irq_src = '0;
  logic        bus_sel = 1'b0, bus_we = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [1:0]  cpu_irq;
  int tests = 0, fails = 0;
  bit done = 1'b0;

  mpic_core u0 (.clk(clk), .rst_n(rst_n), .irq_src(irq_src), .bus_sel(bus_sel),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .cpu_irq(cpu_irq));

  always #4 clk = ~clk;

  function automatic logic [11:0] a_cfg(int n); return 12'h100 + 12'(n * 8); endfunction
  function automatic logic [11:0] a_dst(int n); return 12'h104 + 12'(n * 8); endfunction
  function automatic logic [11:0] a_tpr(int c); return 12'h200 + 12'(c * 16); endfunction
  function automatic logic [11:0] a_ack(int c); return 12'h204 + 12'(c * 16); endfunction
  function automatic logic [11:0] a_eoi(int c); return 12'h208 + 12'(c * 16); endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic wr(logic [11:0] a, logic [31:0] d);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic settle(); repeat (3) @(negedge clk); endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R11 irq", 32'(cpu_irq), 32'h0);
    rd(a_cfg(0), d); chk("R11 cfg", d, 32'h8001_0000);
    rd(a_tpr(1), d); chk("R11 tpr", d, 32'hF);
    rd(12'h008, d);  chk("R11 spur", d, 32'hFF);
    rd(12'h000, d);  chk("R9 feature", d, 32'h0001_0702);
  endtask

  task automatic t_fields();
    logic [31:0] d;
    wr(a_cfg(0), 32'h0003_0520);
    rd(a_cfg(0), d); chk("R1 readback", d, 32'h0003_0520);
    wr(a_cfg(0), 32'h8003_0520);
    rd(a_cfg(0), d); chk("R2 mask readback", d, 32'h8003_0520);
    wr(a_cfg(0), 32'hC003_0520);
    rd(a_cfg(0), d); chk("R1 act read-only", d, 32'h8003_0520);
  endtask

  task automatic t_level();
    logic [31:0] d;
    wr(a_dst(0), 32'h1); wr(a_tpr(0), 32'h0); wr(a_tpr(1), 32'h0);
    irq_src[0] = 1'b1; settle();
    chk("R2 masked", 32'(cpu_irq), 32'h0);
    wr(a_cfg(0), 32'h0003_0520);
    chk("R4 route cpu0 only", 32'(cpu_irq), 32'h1);
    rd(a_cfg(0), d); chk("R3 act pending", d, 32'h4003_0520);
    wr(a_tpr(0), 32'h5); chk("R5 equal blocked", 32'(cpu_irq), 32'h0);
    wr(a_tpr(0), 32'h4); chk("R5 above passes", 32'(cpu_irq), 32'h1);
    wr(a_tpr(0), 32'h0);
    rd(a_ack(0), d); chk("R6 ack vector", d, 32'h20);
    chk("R6 in service", 32'(cpu_irq), 32'h0);
    rd(a_ack(0), d); chk("R6 spurious", d, 32'hFF);
    rd(a_eoi(0), d); chk("R7 eoi read value", d, 32'h0);
    chk("R7 eoi read no effect", 32'(cpu_irq), 32'h0);
    wr(a_eoi(0), 32'h1234);
    chk("R7 eoi retires", 32'(cpu_irq), 32'h1);
    irq_src[0] = 1'b0; settle();
    chk("R10 level drops", 32'(cpu_irq), 32'h0);
    rd(a_cfg(0), d); chk("R3 act clear", d, 32'h0003_0520);
  endtask

  task automatic t_nest();
    logic [31:0] d;
    wr(a_cfg(1), 32'h0003_0331); wr(a_cfg(2), 32'h0003_0632); wr(a_cfg(3), 32'h0003_0633);
    wr(a_dst(1), 32'h1); wr(a_dst(2), 32'h1); wr(a_dst(3), 32'h1);
    irq_src[1] = 1'b1; settle();
    rd(a_ack(0), d); chk("R6 ack low", d, 32'h31);
    irq_src[2] = 1'b1; settle();
    chk("R5 preempt", 32'(cpu_irq), 32'h1);
    rd(a_ack(0), d); chk("R6 ack nested", d, 32'h32);
    irq_src[3] = 1'b1; settle();
    chk("R5 equal to in-service", 32'(cpu_irq), 32'h0);
    rd(a_ack(0), d); chk("R5 spurious nested", d, 32'hFF);
    irq_src[1] = 1'b0; irq_src[2] = 1'b0; settle();
    wr(a_eoi(0), 32'h0);
    rd(a_ack(0), d); chk("R7 retired highest first", d, 32'h33);
    rd(a_cfg(1), d); chk("R3 act in service", d, 32'h4003_0331);
    irq_src[3] = 1'b0;
    wr(a_eoi(0), 32'h0); wr(a_eoi(0), 32'h0); settle();
    rd(a_cfg(1), d); chk("R7 all retired", d, 32'h0003_0331);
    irq_src[2] = 1'b1; irq_src[3] = 1'b1; settle();
    rd(a_ack(0), d); chk("R6 tie lowest index", d, 32'h32);
    irq_src[2] = 1'b0; irq_src[3] = 1'b0; settle();
    wr(a_eoi(0), 32'h0);
    chk("R7 idle", 32'(cpu_irq), 32'h0);
  endtask

  task automatic t_edge();
    logic [31:0] d;
    wr(a_cfg(4), 32'h0000_0740); wr(a_dst(4), 32'h2);
    irq_src[4] = 1'b1; settle();
    chk("R10 wrong edge", 32'(cpu_irq), 32'h0);
    irq_src[4] = 1'b0; settle();
    chk("R10 falling edge, R4 cpu1", 32'(cpu_irq), 32'h2);
    rd(a_ack(1), d); chk("R10 edge ack", d, 32'h40);
    wr(a_eoi(1), 32'h0);
    chk("R10 edge consumed", 32'(cpu_irq), 32'h0);
    wr(12'h008, 32'h5A);
    rd(a_ack(1), d); chk("R6 programmed spurious", d, 32'h5A);
  endtask

  task automatic t_softrst();
    logic [31:0] d;
    irq_src[0] = 1'b1; settle();
    chk("R8 setup", 32'(cpu_irq), 32'h1);
    wr(12'h004, 32'h3);
    rd(12'h004, d); chk("R8 bit set", d, 32'h3);
    rd(12'h004, d); chk("R8 self clear", d, 32'h2);
    chk("R8 irq cleared", 32'(cpu_irq), 32'h0);
    rd(a_cfg(0), d); chk("R8 cfg reset", d, 32'h8001_0000);
    rd(a_dst(0), d); chk("R8 dest reset", d, 32'h0);
    rd(a_tpr(0), d); chk("R8 tpr kept", d, 32'h0);
    irq_src[0] = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fields();
    t_level();
    t_nest();
    t_edge();
    t_softrst();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule